// File: doc/BRIEF.md
# Routed I2C Configuration Writer

This block is a write-only I2C master with its own sequencer. It loads a set of register writes into a peripheral that sits behind an eight-channel I2C bus switch. Each entry in its configuration table is sent in two transactions. The first transaction addresses the switch and writes one control byte that opens its downstream channels, and a stop closes it. The second transaction starts afresh, addresses the peripheral, and writes three payload bytes. The block checks the slave acknowledge after every byte. On the first negative acknowledge it ends the transaction with a stop and halts with an error that carries the index of the failing entry.

Both bus lines are open-drain. Each output pin only chooses between pulling its line low and releasing it. An external pull-up supplies the high level. The bit period is made of four equal quarters derived from the system clock by a divider. The master never stretches the clock: the acknowledge pulse runs at the same rate as the data pulses.

A controller pulses `start` while the block is idle. It then waits for `done` or `error`. Both flags stay set until the next accepted start.

Top module: `cfg_i2c_route_writer`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `error` are low, and `scl_drive_n` and `sda_drive_n` are both 1, which means released.
- R2: A `start` pulse is accepted only while the block is idle and both `scl_in` and `sda_in` read high. On acceptance `busy` rises on the next clock edge. A `start` that arrives while the block is busy, or while the bus is held low, has no effect.
- R3: Every transaction opens with SDA falling while SCL is high and closes with SDA rising while SCL is high. Apart from these two conditions, SDA changes only while SCL is low.
- R4: Each byte is sent MSB first as 8 data clocks followed by a 9th clock, and the master generates all 9 pulses. During the 9th clock the master releases SDA. A low level sampled on that clock is an ACK and a high level is a NACK.
- R5: Within a transaction, consecutive SCL rising edges are always 4×`CLK_DIV` system clocks apart, including across the acknowledge clock. SCL is never stretched.
- R6: Neither line is ever driven high. A drive output of 1 releases its line, and both drive outputs are 1 whenever the block is idle.
- R7: For entry i, the first transaction carries the byte 0xE8, which is the switch address 0x74 with the write bit 0, followed by the control byte `SW_MASK`. The default 0xFF opens all eight channels. A stop then closes the transaction.
- R8: The second transaction for entry i carries 0x72, which is the device address 0x39 with the write bit 0, then the byte i, then i XOR 0xA5, then (i + 0x3C) mod 256. A stop closes it.
- R9: Entries are sent in order from 0 to `N_ENTRIES`−1. After the last stop, `done` rises and `busy` falls. `done` and `error` are never high together, and neither is high while `busy` is high.
- R10: A NACK on any byte is followed by a stop. The block then raises `error`, sets `err_entry` to the index of the entry being sent, clears `busy`, and produces no further SCL pulses.
- R11: An accepted `start` clears both `done` and `error` and runs the sequence again from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run the configuration sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All entries written and acknowledged |
| error | output | 1 | Sequence halted on a NACK |
| err_entry | output | EW | Entry index at which the NACK occurred |
| scl_drive_n | output | 1 | SCL drive, 0 pulls the line low, 1 releases it |
| sda_drive_n | output | 1 | SDA drive, 0 pulls the line low, 1 releases it |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The bench builds the block with `CLK_DIV` = 2 and `N_ENTRIES` = 3. The short quarter keeps each full sequence to roughly fifteen hundred clocks, so it can be repeated many times. With three entries the error index can take a first, a middle and a last value. These values let the slave model place a NACK on the switch address, on the switch control byte, on a payload byte, on the device address of a middle entry, and on the final byte of the last entry. Each case is then checked for the stop that follows and for the halt.

// File: rtl/cfg_i2c_route_writer.sv
module cfg_i2c_route_writer #(
  parameter int          CLK_DIV   = 125,
  parameter int          N_ENTRIES = 4,
  parameter logic [6:0]  SW_ADDR   = 7'h74,
  parameter logic [7:0]  SW_MASK   = 8'hFF,
  parameter logic [6:0]  DEV_ADDR  = 7'h39,
  localparam int         EW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [EW-1:0] err_entry,
  output logic          scl_drive_n,
  output logic          sda_drive_n,
  input  logic          scl_in,
  input  logic          sda_in
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t           st;
  logic [DW-1:0] div;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [1:0]    byten;
  logic          phase;
  logic          nack;
  logic          sda_ctl;
  logic          up;
  logic [EW-1:0] entry;
  logic [7:0]    cur_byte;
  logic          tick;
  logic          last_byte;

  function automatic logic [7:0] byte_at(input logic ph, input logic [1:0] b,
                                          input logic [EW-1:0] e);
    logic [7:0] idx;
    idx = 8'(e);
    if (!ph) return (b == 2'd0) ? {SW_ADDR, 1'b0} : SW_MASK;
    case (b)
      2'd0:    return {DEV_ADDR, 1'b0};
      2'd1:    return idx;
      2'd2:    return idx ^ 8'hA5;
      default: return idx + 8'h3C;
    endcase
  endfunction

  assign cur_byte    = byte_at(phase, byten, entry);
  assign tick        = (div == DW'(CLK_DIV - 1));
  assign last_byte   = phase ? (byten == 2'd3) : (byten == 2'd1);
  assign sda_drive_n = (st == S_BIT) ? ((bitn == 4'd8) ? 1'b1 : cur_byte[~bitn[2:0]])
                                     : sda_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      div         <= '0;
      q           <= '0;
      bitn        <= '0;
      byten       <= '0;
      phase       <= 1'b0;
      nack        <= 1'b0;
      sda_ctl     <= 1'b1;
      scl_drive_n <= 1'b1;
      entry       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      err_entry   <= '0;
      up          <= 1'b0;
    end else begin
      up <= 1'b1;
      if (st == S_IDLE) begin
        div <= '0;
        q   <= '0;
        if (start && scl_in && sda_in) begin
          st        <= S_START;
          busy      <= 1'b1;
          done      <= 1'b0;
          error     <= 1'b0;
          err_entry <= '0;
          entry     <= '0;
          phase     <= 1'b0;
          byten     <= '0;
          nack      <= 1'b0;
        end
      end else if (!tick) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        q   <= q + 2'd1;
        case (st)
          S_START:
            case (q)
              2'd1: sda_ctl <= 1'b0;
              2'd2: scl_drive_n <= 1'b0;
              2'd3: begin
                st   <= S_BIT;
                bitn <= '0;
              end
              default: ;
            endcase
          S_BIT:
            case (q)
              2'd0: scl_drive_n <= 1'b1;
              2'd1: if (bitn == 4'd8) nack <= sda_in;
              2'd2: scl_drive_n <= 1'b0;
              default:
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1;
                end else if (nack || last_byte) begin
                  st      <= S_STOP;
                  sda_ctl <= 1'b0;
                end else begin
                  byten <= byten + 2'd1;
                  bitn  <= '0;
                end
            endcase
          S_STOP:
            case (q)
              2'd0: scl_drive_n <= 1'b1;
              2'd1: sda_ctl <= 1'b1;
              2'd3:
                if (nack) begin
                  st        <= S_IDLE;
                  busy      <= 1'b0;
                  error     <= 1'b1;
                  err_entry <= entry;
                end else if (!phase) begin
                  phase <= 1'b1;
                  byten <= '0;
                  st    <= S_START;
                end else if (entry == EW'(N_ENTRIES - 1)) begin
                  st   <= S_IDLE;
                  busy <= 1'b0;
                  done <= 1'b1;
                end else begin
                  entry <= entry + 1'b1;
                  phase <= 1'b0;
                  byten <= '0;
                  st    <= S_START;
                end
              default: ;
            endcase
          default: ;
        endcase
      end
    end
  end

  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && (sda_drive_n != $past(sda_drive_n)) && $past(scl_drive_n))
      |-> ($past(st) == S_START || $past(st) == S_STOP));

  // R6
  idle_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (scl_drive_n && sda_drive_n));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !error));

  // R5
  scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && !tick) |=> $stable(scl_drive_n));

  // R10
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> (error && scl_drive_n));
endmodule

// File: tb/sim_cfg_i2c_route_writer.sv
`timescale 1ns/1ps
module sim_cfg_i2c_route_writer;
  localparam int DIV = 2;
  localparam int NE  = 3;
  localparam int NB  = NE * 6;
  localparam int NV  = 6;
  // nack byte (255 = none), error expected, error entry expected
  localparam int VEC [NV][3] = '{'{255, 0, 0}, '{0, 1, 0}, '{1, 1, 0},
                                 '{3, 1, 0}, '{8, 1, 1}, '{17, 1, 2}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, error;
  logic [1:0] err_entry;
  logic scl_drive_n, sda_drive_n;
  logic slave_sda = 1'b1, hold_bus = 1'b1;
  wire  scl_line = scl_drive_n;
  wire  sda_line = sda_drive_n & slave_sda & hold_bus;

  always #2 clk = ~clk;

  cfg_i2c_route_writer #(.CLK_DIV(DIV), .N_ENTRIES(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .err_entry(err_entry), .scl_drive_n(scl_drive_n),
    .sda_drive_n(sda_drive_n), .scl_in(scl_line), .sda_in(sda_line));

  int checks = 0, fails = 0;
  int bitc = 0, nbytes = 0, nstart = 0, nstop = 0, nscl = 0, bad_period = 0;
  int nack_at = 255;
  logic [7:0] shv = 8'h00;
  logic [7:0] log_b [64];
  realtime last_rise = 0.0;
  bit have_rise = 1'b0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    nstart++; bitc = 0; have_rise = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    nstop++; have_rise = 1'b0;
  end
  always @(posedge scl_line) begin
    nscl++;
    if (have_rise && (($realtime - last_rise) > 4.0*DIV*4.0 + 0.01 ||
                      ($realtime - last_rise) < 4.0*DIV*4.0 - 0.01)) bad_period++;
    last_rise = $realtime;
    have_rise = 1'b1;
    if (bitc < 8) begin
      shv = {shv[6:0], sda_line};
      bitc++;
      if (bitc == 8 && nbytes < 64) log_b[nbytes] = shv;
    end else bitc = 9;
  end
  always @(negedge scl_line) begin
    if (bitc == 8) slave_sda = (nbytes == nack_at) ? 1'b1 : 1'b0;
    else if (bitc == 9) begin slave_sda = 1'b1; bitc = 0; nbytes++; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_byte(input int g);
    int e;
    e = g / 6;
    case (g % 6)
      0: return 'hE8;
      1: return 'hFF;
      2: return 'h72;
      3: return e;
      4: return (e ^ 'hA5) & 'hFF;
      default: return (e + 'h3C) & 'hFF;
    endcase
  endfunction

  task automatic clear_mon();
    nbytes = 0; nstart = 0; nstop = 0; bad_period = 0; bitc = 0; have_rise = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    while (!(done || error)) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int k, nb, tr, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    chk("R1 scl released", scl_drive_n, 1);
    chk("R1 sda released", sda_drive_n, 1);

    for (int v = 0; v < NV; v++) begin
      k = VEC[v][0];
      nack_at = k;
      clear_mon();
      kick();
      chk("R2 busy after start", busy, 1);
      chk("R11 flags cleared", int'(done | error), 0);
      wait_end();
      nb = (k == 255) ? NB : k + 1;
      tr = (k == 255) ? 2 * NE : 2 * (k / 6) + (((k % 6) >= 2) ? 2 : 1);
      chk($sformatf("R10 error v%0d", v), error, VEC[v][1]);
      chk($sformatf("R9 done v%0d", v), done, VEC[v][1] ? 0 : 1);
      chk("R9 busy low at end", busy, 0);
      if (VEC[v][1] != 0) chk($sformatf("R10 err_entry v%0d", v), int'(err_entry), VEC[v][2]);
      chk($sformatf("R4 byte count v%0d", v), nbytes, nb);
      for (int i = 0; i < nb; i++)
        chk($sformatf("R7/R8 byte %0d v%0d", i, v), int'(log_b[i]), exp_byte(i));
      chk($sformatf("R3 starts v%0d", v), nstart, tr);
      chk($sformatf("R3 stops v%0d", v), nstop, tr);
      chk($sformatf("R5 scl period v%0d", v), bad_period, 0);
      if (VEC[v][1] != 0) begin
        s = nscl;
        repeat (100) @(negedge clk);
        chk("R10 no scl after error", nscl, s);
        chk("R10 error held", error, 1);
        chk("R6 scl released idle", scl_drive_n, 1);
        chk("R6 sda released idle", sda_drive_n, 1);
      end
    end

    // R2 start while busy is ignored
    nack_at = 255;
    clear_mon();
    kick();
    repeat (300) @(negedge clk);
    kick();
    wait_end();
    chk("R2 restart ignored starts", nstart, 2 * NE);
    chk("R2 restart ignored bytes", nbytes, NB);
    chk("R2 restart ignored done", done, 1);

    // R2 start refused while bus held low
    hold_bus = 1'b0;
    repeat (4) @(negedge clk);
    s = nscl;
    kick();
    repeat (40) @(negedge clk);
    chk("R2 bus low no busy", busy, 0);
    chk("R2 bus low no scl", nscl, s);
    chk("R2 bus low done kept", done, 1);
    hold_bus = 1'b1;
    repeat (4) @(negedge clk);

    // R11 rerun after a completed sequence
    clear_mon();
    kick();
    wait_end();
    chk("R11 rerun done", done, 1);
    chk("R11 rerun bytes", nbytes, NB);
    chk("R11 rerun first byte", int'(log_b[0]), 'hE8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule